// File: doc/BRIEF.md
# Label-Filtered Receive Buffer with Change Suppression

This block sits behind a serial avionics word receiver and decides, word by word, whether each received 32-bit word is kept. A per-label acceptance table can reject words by their label. A change-suppression mode keeps the most recent word seen for every label and discards a new word that repeats it. The words that are kept go into a first-in first-out store. The host drains that store through a show-ahead pop port that reports empty, full and an entry count.

When timestamping is on, every kept word takes two consecutive store entries. The data word comes first and the free-running timestamp captured with it comes second. The store therefore holds 256 plain words, or 128 word and timestamp pairs. Any toggle of the timestamp mode empties the store, so that data and timestamp entries never fall out of step. When no room is left, new words are dropped and a sticky overflow flag is raised until the host clears it.

Top module: `rx_label_buffer`

## Requirements
- R1: The label of a word is its bits [7:0]. While the filter is enabled, a word is kept only when the table bit for its label is 1. The table is written through the table write port. Reset clears every table bit, which means reject.
- R2: While the filter is disabled, every received word passes the filter, whatever the table holds.
- R3: While change suppression is enabled, a passing word is stored only when it differs from the last word held for its label. An equal word is discarded.
- R4: The last-word memory is updated by every word that passes the filter, whether or not it is stored and whatever the suppression setting. Words rejected by the filter leave it untouched.
- R5: The first word that passes for a label after reset always counts as changed.
- R6: With timestamps off, every stored word takes one entry. The capacity is 256 entries, and full is high when count is 256.
- R7: With timestamps on, every stored word is written as two entries in the same cycle: the data word, then `in_stamp`. The capacity is 128 pairs, and full is high whenever fewer than 2 entries are free.
- R8: A word that should be stored but finds no room is dropped, and `overflow` is set. `overflow` stays high until `ovf_clear` is pulsed. A new overflow in the same cycle as a clear wins.
- R9: A change of `cfg_stamp_en` empties the store one cycle later. A word or pop in that cycle has no effect on the store.
- R10: `pop_word` shows the oldest entry. A pop while empty is ignored. `empty` is high exactly when `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received word strobe |
| in_word | input | 32 | Received word, label in bits [7:0] |
| in_stamp | input | 32 | Free-running timestamp |
| cfg_filter_en | input | 1 | Enable label acceptance filter |
| cfg_change_en | input | 1 | Enable change suppression |
| cfg_stamp_en | input | 1 | Enable timestamp pairs |
| tbl_we | input | 1 | Acceptance table write strobe |
| tbl_addr | input | 8 | Label to program |
| tbl_accept | input | 1 | Accept bit to write |
| pop | input | 1 | Remove the oldest entry |
| pop_word | output | 32 | Oldest entry (show-ahead) |
| empty | output | 1 | Store is empty |
| full | output | 1 | No room for another word |
| count | output | 9 | Entries held |
| overflow | output | 1 | Sticky drop flag |
| ovf_clear | input | 1 | Clear the overflow flag |

## Verification
A corrupted acceptance bit or last-word entry shows up at the ports on the next word carrying that label. That word's store decision shows on `count` one cycle after its strobe. A stale valid bit is caught by sending the same label first with suppression off and then with it on. Pointer or count damage shows as a wrong `pop_word` on the next pop, or as `full` asserting at the wrong fill level. These effects are observed both at the 256-entry and the 128-pair boundary. A misaligned pair shows when a timestamp appears where a data word is expected, straight after a mode switch.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_ONE  = 2'd1,
      WR_PAIR = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/rxb_accept_table.sv
module rxb_accept_table #(
   parameter int LABEL_W = 8,
   localparam int N_LABELS = 1 << LABEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [LABEL_W-1:0] waddr,
   input  logic               wbit,
   input  logic [LABEL_W-1:0] raddr,
   output logic               accept
);
   logic [N_LABELS-1:0] bits_q;

   // one flop per label, each with its own write decode
   for (genvar i = 0; i < N_LABELS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bits_q[i] <= 1'b0;
         else if (we && waddr == LABEL_W'(i))
            bits_q[i] <= wbit;
      end
   end

   assign accept = bits_q[raddr];
endmodule

// File: rtl/rxb_last_value.sv
module rxb_last_value #(
   parameter int WORD_W  = 32,
   parameter int LABEL_W = 8,
   localparam int N_LABELS = 1 << LABEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd,
   input  logic [LABEL_W-1:0] idx,
   input  logic [WORD_W-1:0]  word,
   output logic               seen,
   output logic [WORD_W-1:0]  last
);
   logic [N_LABELS-1:0] seen_q;
   logic [WORD_W-1:0]   data_q [N_LABELS];

   // only the valid bits need reset; data is qualified by them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= '0;
      else if (upd)
         seen_q[idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (upd)
         data_q[idx] <= word;
   end

   assign seen = seen_q[idx];
   assign last = data_q[idx];
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo import rxb_pkg::*; #(
   parameter int W     = 32,
   parameter int DEPTH = 256,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  wr_kind_e         wr_kind,
   input  logic [W-1:0]     din_a,
   input  logic [W-1:0]     din_b,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             no_room_one,
   output logic             no_room_two
);
   logic [PTR_W-1:0] wptr_q, rptr_q, wptr_b;
   logic [CNT_W-1:0] step_in;
   logic             do_pop, do_wr;
   logic [W-1:0]     mem [DEPTH];

   assign wptr_b  = wptr_q + 1'b1;
   assign do_wr   = (wr_kind != WR_NONE) && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign step_in = !do_wr ? '0 : (wr_kind == WR_PAIR) ? CNT_W'(2) : CNT_W'(1);

   // a pair lands in two neighbouring cells in one cycle
   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (do_wr && wptr_q == PTR_W'(i))
            mem[i] <= din_a;
         else if (do_wr && wr_kind == WR_PAIR && wptr_b == PTR_W'(i))
            mem[i] <= din_b;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         count  <= '0;
      end else if (flush) begin
         wptr_q <= '0;
         rptr_q <= '0;
         count  <= '0;
      end else begin
         wptr_q <= wptr_q + step_in[PTR_W-1:0];
         rptr_q <= rptr_q + PTR_W'(do_pop);
         count  <= count + step_in - CNT_W'(do_pop);
      end
   end

   assign dout        = mem[rptr_q];
   assign empty       = (count == '0);
   assign no_room_one = (count == CNT_W'(DEPTH));
   assign no_room_two = (count > CNT_W'(DEPTH - 2));
endmodule

// File: rtl/rx_label_buffer.sv
module rx_label_buffer import rxb_pkg::*; #(
   parameter int WORD_W  = 32,
   parameter int LABEL_W = 8,
   parameter int DEPTH   = 256,
   localparam int CNT_W  = $clog2(DEPTH) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [WORD_W-1:0]  in_word,
   input  logic [WORD_W-1:0]  in_stamp,
   input  logic               cfg_filter_en,
   input  logic               cfg_change_en,
   input  logic               cfg_stamp_en,
   input  logic               tbl_we,
   input  logic [LABEL_W-1:0] tbl_addr,
   input  logic               tbl_accept,
   input  logic               pop,
   output logic [WORD_W-1:0]  pop_word,
   output logic               empty,
   output logic               full,
   output logic [CNT_W-1:0]   count,
   output logic               overflow,
   input  logic               ovf_clear
);
   if (LABEL_W < 1 || LABEL_W > WORD_W) begin : g_bad_label
      $error("LABEL_W must fit inside WORD_W");
   end
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end

   logic [LABEL_W-1:0] label;
   logic               accept, seen, passed, changed, want, room, flush, stamp_q;
   logic               no_room_one, no_room_two;
   logic [WORD_W-1:0]  last;
   wr_kind_e           wr_kind;

   assign label = in_word[LABEL_W-1:0];

   rxb_accept_table #(.LABEL_W(LABEL_W)) i_table (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr),
      .wbit(tbl_accept), .raddr(label), .accept(accept)
   );

   assign passed = in_valid && (!cfg_filter_en || accept);

   rxb_last_value #(.WORD_W(WORD_W), .LABEL_W(LABEL_W)) i_last (
      .clk(clk), .rst_n(rst_n), .upd(passed), .idx(label),
      .word(in_word), .seen(seen), .last(last)
   );

   assign changed = !cfg_change_en || !seen || (last != in_word);
   assign want    = passed && changed;

   // mode register: any toggle of the timestamp mode flushes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stamp_q <= 1'b0;
      else        stamp_q <= cfg_stamp_en;
   end
   assign flush = (cfg_stamp_en != stamp_q);

   assign room = cfg_stamp_en ? !no_room_two : !no_room_one;
   assign full = cfg_stamp_en ? no_room_two : no_room_one;

   always_comb begin
      wr_kind = WR_NONE;
      if (want && room && !flush)
         wr_kind = cfg_stamp_en ? WR_PAIR : WR_ONE;
   end

   rxb_fifo #(.W(WORD_W), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_kind(wr_kind),
      .din_a(in_word), .din_b(in_stamp), .pop(pop), .dout(pop_word),
      .count(count), .empty(empty), .no_room_one(no_room_one),
      .no_room_two(no_room_two)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         overflow <= 1'b0;
      else if (want && !room && !flush)
         overflow <= 1'b1;
      else if (ovf_clear)
         overflow <= 1'b0;
   end
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
   parameter int DEPTH = 256,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             pop,
   input logic             empty,
   input logic             full,
   input logic             overflow,
   input logic             ovf_clear,
   input logic             cfg_stamp_en,
   input logic [CNT_W-1:0] count
);
   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   a_r10_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (count == '0));

   a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow && !ovf_clear |=> overflow);

   a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(in_valid) && $past(full));

   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && (cfg_stamp_en != $past(cfg_stamp_en)) |=> empty);

   a_r6_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      full && !pop |=> count <= $past(count));

   a_r7_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && cfg_stamp_en && $past(cfg_stamp_en) && !pop
      |=> count[0] == $past(count[0]));
endmodule

bind rx_label_buffer rxb_checker #(.DEPTH(DEPTH)) i_rxb_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pop(pop),
   .empty(empty), .full(full), .overflow(overflow), .ovf_clear(ovf_clear),
   .cfg_stamp_en(cfg_stamp_en), .count(count)
);

// File: tb/test_rx_label_buffer.sv
module test_rx_label_buffer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic [31:0] in_stamp = '0;
   logic        cfg_filter_en = 1'b0;
   logic        cfg_change_en = 1'b0;
   logic        cfg_stamp_en = 1'b0;
   logic        tbl_we = 1'b0;
   logic [7:0]  tbl_addr = '0;
   logic        tbl_accept = 1'b0;
   logic        pop = 1'b0;
   logic        ovf_clear = 1'b0;
   logic [31:0] pop_word;
   logic        empty, full, overflow;
   logic [8:0]  count;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rx_label_buffer i_rx_label_buffer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .in_stamp(in_stamp), .cfg_filter_en(cfg_filter_en),
      .cfg_change_en(cfg_change_en), .cfg_stamp_en(cfg_stamp_en),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_accept(tbl_accept),
      .pop(pop), .pop_word(pop_word), .empty(empty), .full(full),
      .count(count), .overflow(overflow), .ovf_clear(ovf_clear)
   );

   function automatic logic [31:0] fill_word(input int i);
      return {8'(i), 8'(i) ^ 8'hA5, 8'h3C, 8'(i)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] w, input logic [31:0] ts);
      @(negedge clk);
      in_valid = 1'b1; in_word = w; in_stamp = ts;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic prog(input logic [7:0] lbl, input logic bitv);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = lbl; tbl_accept = bitv;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic pop_check(input logic [31:0] exp, input string req);
      chk(pop_word == exp, req, pop_word, exp);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
   endtask

   task automatic clear_ovf();
      ovf_clear = 1'b1;
      @(negedge clk);
      ovf_clear = 1'b0;
   endtask

   task automatic t_reset();
      chk(empty == 1'b1, "R10 empty after reset", 32'(empty), 32'd1);
      chk(count == 9'd0, "R10 count after reset", 32'(count), 32'd0);
      chk(full == 1'b0, "R6 full after reset", 32'(full), 32'd0);
      chk(overflow == 1'b0, "R8 overflow after reset", 32'(overflow), 32'd0);
   endtask

   task automatic t_filter();
      cfg_filter_en = 1'b1;
      send(32'h1111_0012, 0);
      chk(count == 9'd0, "R1 reset table rejects", 32'(count), 32'd0);
      prog(8'h12, 1'b1);
      send(32'h2222_0012, 0);
      chk(count == 9'd1, "R1 programmed label kept", 32'(count), 32'd1);
      send(32'h3333_0013, 0);
      chk(count == 9'd1, "R1 other label rejected", 32'(count), 32'd1);
      pop_check(32'h2222_0012, "R1 stored word");
      cfg_filter_en = 1'b0;
   endtask

   task automatic t_nofilter();
      send(32'h4444_0013, 0);
      send(32'h5555_0044, 0);
      chk(count == 9'd2, "R2 filter off keeps all", 32'(count), 32'd2);
      pop_check(32'h4444_0013, "R2 order first");
      pop_check(32'h5555_0044, "R2 order second");
   endtask

   task automatic t_change();
      cfg_change_en = 1'b1;
      send(32'hAAAA_0055, 0);
      chk(count == 9'd1, "R5 first word counts changed", 32'(count), 32'd1);
      send(32'hAAAA_0055, 0);
      chk(count == 9'd1, "R3 repeat discarded", 32'(count), 32'd1);
      send(32'hBBBB_0055, 0);
      chk(count == 9'd2, "R3 new value stored", 32'(count), 32'd2);
      send(32'hBBBB_0055, 0);
      chk(count == 9'd2, "R3 repeat discarded again", 32'(count), 32'd2);
      pop_check(32'hAAAA_0055, "R3 first value");
      pop_check(32'hBBBB_0055, "R3 second value");
   endtask

   task automatic t_last_update();
      cfg_change_en = 1'b0;
      send(32'hCCCC_0066, 0);
      cfg_change_en = 1'b1;
      send(32'hCCCC_0066, 0);
      chk(count == 9'd1, "R4 memory updated with suppression off", 32'(count), 32'd1);
      pop_check(32'hCCCC_0066, "R4 stored word");
      cfg_filter_en = 1'b1;
      send(32'hDDDD_0077, 0);
      chk(count == 9'd0, "R1 unprogrammed label rejected", 32'(count), 32'd0);
      cfg_filter_en = 1'b0;
      send(32'hDDDD_0077, 0);
      chk(count == 9'd1, "R4 rejected word left memory alone", 32'(count), 32'd1);
      pop_check(32'hDDDD_0077, "R4 stored word");
      cfg_change_en = 1'b0;
   endtask

   task automatic t_capacity();
      for (int i = 0; i < 256; i++) send(fill_word(i), 0);
      chk(count == 9'd256, "R6 count at capacity", 32'(count), 32'd256);
      chk(full == 1'b1, "R6 full at capacity", 32'(full), 32'd1);
      chk(overflow == 1'b0, "R8 no overflow yet", 32'(overflow), 32'd0);
      send(32'hEEEE_0001, 0);
      chk(count == 9'd256, "R8 extra word dropped", 32'(count), 32'd256);
      chk(overflow == 1'b1, "R8 overflow set", 32'(overflow), 32'd1);
      repeat (3) @(negedge clk);
      chk(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 32'd1);
      clear_ovf();
      chk(overflow == 1'b0, "R8 overflow cleared", 32'(overflow), 32'd0);
      for (int i = 0; i < 256; i++) pop_check(fill_word(i), "R6 drain order");
      chk(empty == 1'b1, "R10 empty after drain", 32'(empty), 32'd1);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      chk(count == 9'd0, "R10 pop while empty ignored", 32'(count), 32'd0);
   endtask

   task automatic t_stamp();
      send(32'h1234_0021, 0);
      chk(count == 9'd1, "R9 setup word stored", 32'(count), 32'd1);
      @(negedge clk);
      cfg_stamp_en = 1'b1;
      in_valid = 1'b1; in_word = 32'h5678_0022; in_stamp = 32'h99;
      @(negedge clk);
      in_valid = 1'b0;
      chk(count == 9'd0, "R9 toggle flushes and drops word", 32'(count), 32'd0);
      send(32'hABCD_0023, 32'h0000_7777);
      chk(count == 9'd2, "R7 pair takes two entries", 32'(count), 32'd2);
      pop_check(32'hABCD_0023, "R7 data first");
      pop_check(32'h0000_7777, "R7 stamp second");
      for (int i = 0; i < 128; i++) send(fill_word(i), 32'h100 + 32'(i));
      chk(count == 9'd256, "R7 128 pairs fill", 32'(count), 32'd256);
      chk(full == 1'b1, "R7 full at 128 pairs", 32'(full), 32'd1);
      send(32'hFFFF_0031, 32'h1);
      chk(overflow == 1'b1, "R8 overflow in stamp mode", 32'(overflow), 32'd1);
      clear_ovf();
      pop_check(fill_word(0), "R7 first pair data");
      chk(full == 1'b1, "R7 one free entry still full", 32'(full), 32'd1);
      send(32'hFFFF_0032, 32'h2);
      chk(count == 9'd255, "R7 no half pair written", 32'(count), 32'd255);
      chk(overflow == 1'b1, "R8 overflow on single free entry", 32'(overflow), 32'd1);
      pop_check(32'h100, "R7 first pair stamp");
      chk(full == 1'b0, "R7 two free entries not full", 32'(full), 32'd0);
      pop_check(fill_word(1), "R7 second pair data");
      @(negedge clk);
      cfg_stamp_en = 1'b0;
      @(negedge clk);
      chk(count == 9'd0, "R9 toggle off flushes", 32'(count), 32'd0);
      clear_ovf();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_filter();
      t_nofilter();
      t_change();
      t_last_update();
      t_capacity();
      t_stamp();
      summary();
      $finish;
   end
endmodule